// File: doc/BRIEF.md
# Multi-Level Memory Protection Unit

This block decides whether each bus access may go ahead. The address space is the full 24-bit range, and the peripheral range is part of it. Four privilege levels exist. Each level owns a separate bank of four address windows. Every window has an inclusive lower bound, an inclusive upper bound and three rights bits of its own: data read, data write and instruction fetch. The access arrives with its address, its kind and the level that is active at that moment. The verdict is combinational. An access is granted when some window of the active level covers the address and has the right for that kind set. If no window qualifies, the access is refused.

A refused access that is marked valid produces a protection trap. The trap is a one-cycle registered pulse. With it the block registers the faulting address, kind and level, and it holds them until the next violation. When the unit is switched off, every access is granted.

A small write-only configuration port programs the windows and the global switch. Software can reload a level's windows at run time, which lets it emulate more than four levels. A write changes behaviour from the following cycle onward.

Top module: `mpu_top`

## Requirements
- R1: After reset the unit is disabled, `trap` is low, `trap_addr`/`trap_type`/`trap_level` are zero, and every window has bounds 0 and no rights.
- R2: While disabled, `acc_ok` is high for every address, kind and level, and `trap` never rises.
- R3: While enabled, `acc_ok` is high exactly when at least one window of level `acc_level` satisfies lower <= `acc_addr` <= upper and has the rights bit for `acc_type` set.
- R4: Both window bounds are inclusive: the lower and upper addresses are granted, and lower-1 and upper+1 are refused when no other window covers them.
- R5: Rights are independent. Bit 0 grants read (`acc_type`=0), bit 1 grants write (`acc_type`=1) and bit 2 grants fetch (`acc_type`=2). `acc_type`=3 is never granted while enabled.
- R6: Each level uses only its own windows. A window programmed in one level has no effect on accesses made at another level.
- R7: If `acc_valid` is high and `acc_ok` is low in a cycle, `trap` is high for exactly the next cycle. In that cycle `trap_addr`, `trap_type` and `trap_level` hold the values of that access. Otherwise `trap` is low and the captured fields keep their values.
- R8: A configuration write takes effect on the cycle after `cfg_we`. An access presented in the same cycle as the write is judged against the old settings.
- R9: Configuration map, with `cfg_addr` = {level[5:4], window[3:2], field[1:0]}. Field 0 writes the lower bound and field 1 the upper bound, both from `cfg_wdata[23:0]`. Field 2 writes the rights from `cfg_wdata[2:0]`. Field 3 writes the global enable from `cfg_wdata[0]` and ignores the level and window bits.
- R10: Checking covers the whole address space. A window from 0x000000 to 0xFFFFFF grants the top address 0xFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration target {level, window, field} |
| cfg_wdata | input | 24 | Configuration write data |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 24 | Access address |
| acc_type | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| acc_level | input | 2 | Active protection level |
| acc_ok | output | 1 | Combinational grant verdict |
| trap | output | 1 | One-cycle protection trap pulse |
| trap_addr | output | 24 | Address of the last violating access |
| trap_type | output | 2 | Kind of the last violating access |
| trap_level | output | 2 | Level of the last violating access |

## Verification
On every cycle the assertions check the trap timing and what it captures, that the captured fields stay stable between violations, that every access is granted while the unit is off, and that the reserved kind is refused. Only the bench scenarios can show the windowing itself. That covers inclusive edges, the separation between levels, the independence of the rights bits, the same-cycle write ordering and the top of the address space. The bench compares each verdict against a model of the programmed windows.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  localparam logic [1:0] FLD_LO   = 2'd0;
  localparam logic [1:0] FLD_HI   = 2'd1;
  localparam logic [1:0] FLD_PERM = 2'd2;
  localparam logic [1:0] FLD_EN   = 2'd3;

  localparam int PERM_W = 3;
endpackage

// File: rtl/mpu_regbank.sv
module mpu_regbank
  import mpu_pkg::*;
#(
  parameter int LEVELS  = 4,
  parameter int REGIONS = 4,
  parameter int ADDR_W  = 24,
  localparam int LVL_W  = $clog2(LEVELS),
  localparam int RGN_W  = $clog2(REGIONS),
  localparam int CFG_AW = LVL_W + RGN_W + 2,
  localparam int SLOTS  = LEVELS * REGIONS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic [LVL_W-1:0]  lvl_sel,
  output logic [ADDR_W-1:0] sel_lo   [REGIONS],
  output logic [ADDR_W-1:0] sel_hi   [REGIONS],
  output logic [PERM_W-1:0] sel_perm [REGIONS],
  output logic              enable
);
  logic [ADDR_W-1:0] lo_q   [SLOTS];
  logic [ADDR_W-1:0] hi_q   [SLOTS];
  logic [PERM_W-1:0] perm_q [SLOTS];

  logic [1:0]             fld;
  logic [LVL_W+RGN_W-1:0] slot;

  assign fld  = cfg_addr[1:0];
  assign slot = cfg_addr[CFG_AW-1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      enable <= 1'b0;
      for (int i = 0; i < SLOTS; i++) begin
        lo_q[i]   <= '0;
        hi_q[i]   <= '0;
        perm_q[i] <= '0;
      end
    end else if (cfg_we) begin
      case (fld)
        FLD_LO:   lo_q[slot]   <= cfg_wdata;
        FLD_HI:   hi_q[slot]   <= cfg_wdata;
        FLD_PERM: perm_q[slot] <= cfg_wdata[PERM_W-1:0];
        default:  enable       <= cfg_wdata[0];
      endcase
    end
  end

  for (genvar r = 0; r < REGIONS; r++) begin : g_sel
    logic [LVL_W+RGN_W-1:0] idx;
    assign idx         = {lvl_sel, RGN_W'(r)};
    assign sel_lo[r]   = lo_q[idx];
    assign sel_hi[r]   = hi_q[idx];
    assign sel_perm[r] = perm_q[idx];
  end
endmodule

// File: rtl/mpu_region_match.sv
module mpu_region_match
  import mpu_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic [PERM_W-1:0] perm,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        kind,
  output logic              grant
);
  logic inside_win;
  logic right_ok;

  assign inside_win = (addr >= lo) && (addr <= hi);

  always_comb begin
    case (kind)
      ACC_READ:  right_ok = perm[0];
      ACC_WRITE: right_ok = perm[1];
      ACC_FETCH: right_ok = perm[2];
      default:   right_ok = 1'b0;
    endcase
  end

  assign grant = inside_win && right_ok;
endmodule

// File: rtl/mpu_trap.sv
module mpu_trap #(
  parameter int ADDR_W = 24,
  parameter int LVL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              violate,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        kind,
  input  logic [LVL_W-1:0]  level,
  output logic              trap,
  output logic [ADDR_W-1:0] trap_addr,
  output logic [1:0]        trap_type,
  output logic [LVL_W-1:0]  trap_level
);
  always_ff @(posedge clk) begin
    if (rst) begin
      trap       <= 1'b0;
      trap_addr  <= '0;
      trap_type  <= '0;
      trap_level <= '0;
    end else begin
      trap <= violate;
      if (violate) begin
        trap_addr  <= addr;
        trap_type  <= kind;
        trap_level <= level;
      end
    end
  end
endmodule

// File: rtl/mpu_top.sv
module mpu_top
  import mpu_pkg::*;
#(
  parameter int LEVELS  = 4,
  parameter int REGIONS = 4,
  parameter int ADDR_W  = 24,
  localparam int LVL_W  = $clog2(LEVELS),
  localparam int CFG_AW = LVL_W + $clog2(REGIONS) + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_type,
  input  logic [LVL_W-1:0]  acc_level,
  output logic              acc_ok,
  output logic              trap,
  output logic [ADDR_W-1:0] trap_addr,
  output logic [1:0]        trap_type,
  output logic [LVL_W-1:0]  trap_level
);
  logic [ADDR_W-1:0] w_lo   [REGIONS];
  logic [ADDR_W-1:0] w_hi   [REGIONS];
  logic [PERM_W-1:0] w_perm [REGIONS];
  logic [REGIONS-1:0] hits;
  logic mpu_en;

  mpu_regbank #(.LEVELS(LEVELS), .REGIONS(REGIONS), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .lvl_sel(acc_level),
    .sel_lo(w_lo), .sel_hi(w_hi), .sel_perm(w_perm), .enable(mpu_en)
  );

  for (genvar r = 0; r < REGIONS; r++) begin : g_win
    mpu_region_match #(.ADDR_W(ADDR_W)) u_match (
      .lo(w_lo[r]), .hi(w_hi[r]), .perm(w_perm[r]),
      .addr(acc_addr), .kind(acc_type), .grant(hits[r])
    );
  end

  assign acc_ok = !mpu_en || (|hits);

  mpu_trap #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_trap (
    .clk(clk), .rst(rst), .violate(acc_valid && !acc_ok),
    .addr(acc_addr), .kind(acc_type), .level(acc_level),
    .trap(trap), .trap_addr(trap_addr), .trap_type(trap_type),
    .trap_level(trap_level)
  );
endmodule

// File: rtl/mpu_chk.sv
module mpu_chk #(
  parameter int ADDR_W = 24,
  parameter int LVL_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [1:0]        acc_type,
  input logic [LVL_W-1:0]  acc_level,
  input logic              acc_ok,
  input logic              trap,
  input logic [ADDR_W-1:0] trap_addr,
  input logic [1:0]        trap_type,
  input logic [LVL_W-1:0]  trap_level,
  input logic              mpu_en
);
  // R2
  off_grants_chk: assert property (@(posedge clk) disable iff (rst)
    !mpu_en |-> acc_ok);

  // R5
  rsvd_denied_chk: assert property (@(posedge clk) disable iff (rst)
    (mpu_en && acc_type == 2'd3) |-> !acc_ok);

  // R7
  trap_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_ok) |=> trap);

  // R7
  trap_cause_chk: assert property (@(posedge clk) disable iff (rst)
    trap |-> ($past(acc_valid) && !$past(acc_ok)
              && trap_addr == $past(acc_addr)
              && trap_type == $past(acc_type)
              && trap_level == $past(acc_level)));

  // R7
  capture_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !trap |-> ($stable(trap_addr) && $stable(trap_type) && $stable(trap_level)));
endmodule

bind mpu_top mpu_chk #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .acc_type(acc_type), .acc_level(acc_level), .acc_ok(acc_ok),
  .trap(trap), .trap_addr(trap_addr), .trap_type(trap_type),
  .trap_level(trap_level), .mpu_en(mpu_en)
);

// File: tb/mpu_top_bench.sv
module mpu_top_bench;
  localparam int AW = 24;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [5:0] cfg_addr = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic acc_valid = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [1:0] acc_type = '0;
  logic [1:0] acc_level = '0;
  logic acc_ok, trap;
  logic [AW-1:0] trap_addr;
  logic [1:0] trap_type, trap_level;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [AW-1:0] m_lo [16];
  logic [AW-1:0] m_hi [16];
  logic [2:0]    m_pm [16];
  bit m_en;

  always #2 clk = ~clk;

  mpu_top u_mpu_top (.*);

  function automatic bit exp_ok(input logic [AW-1:0] a, input logic [1:0] t,
                                input logic [1:0] l);
    if (!m_en) return 1'b1;
    if (t == 2'd3) return 1'b0;
    for (int r = 0; r < 4; r++) begin
      int s = l * 4 + r;
      if (a >= m_lo[s] && a <= m_hi[s] && m_pm[s][t]) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic chk(input bit cond, input string req, input longint act, input longint exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] l, input logic [1:0] r, input logic [1:0] f,
                     input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = {l, r, f}; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 0;
    case (f)
      2'd0: m_lo[l*4+r] = d;
      2'd1: m_hi[l*4+r] = d;
      2'd2: m_pm[l*4+r] = d[2:0];
      default: m_en = d[0];
    endcase
  endtask

  task automatic win(input logic [1:0] l, input logic [1:0] r, input logic [AW-1:0] lo,
                     input logic [AW-1:0] hi, input logic [2:0] pm);
    cfg(l, r, 2'd0, lo);
    cfg(l, r, 2'd1, hi);
    cfg(l, r, 2'd2, {21'd0, pm});
  endtask

  // Present one valid access, check the verdict, then the trap in the next cycle.
  task automatic access(input logic [AW-1:0] a, input logic [1:0] t, input logic [1:0] l,
                        input string req);
    bit e;
    @(negedge clk);
    acc_valid = 1; acc_addr = a; acc_type = t; acc_level = l;
    e = exp_ok(a, t, l);
    #1;
    chk(acc_ok == e, req, acc_ok, e);
    @(posedge clk);
    @(negedge clk);
    acc_valid = 0;
    #1;
    chk(trap == !e, {req, "/R7 trap"}, trap, !e);
    if (!e) chk(trap_addr == a && trap_type == t && trap_level == l, "R7 capture",
                {trap_addr, trap_type, trap_level}, {a, t, l});
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234));
    for (int i = 0; i < 16; i++) begin m_lo[i] = 0; m_hi[i] = 0; m_pm[i] = 0; end
    m_en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    #1;
    // R1 reset state
    chk(trap == 0 && trap_addr == 0 && trap_type == 0 && trap_level == 0, "R1", trap, 0);
    chk(acc_ok == 1, "R1 disabled", acc_ok, 1);

    // R2 disabled passes everything
    for (int i = 0; i < 8; i++) access($urandom, 2'($urandom), 2'($urandom), "R2");

    // R9 enable via field 3; empty windows -> R3 refused
    cfg(2'd2, 2'd1, 2'd3, 24'd1);
    access(24'h000010, 2'd0, 2'd0, "R9/R3 empty");

    // R4 inclusive bounds
    win(2'd0, 2'd0, 24'h001000, 24'h001FFF, 3'b001);
    access(24'h001000, 2'd0, 2'd0, "R4 lo");
    access(24'h001FFF, 2'd0, 2'd0, "R4 hi");
    access(24'h000FFF, 2'd0, 2'd0, "R4 lo-1");
    access(24'h002000, 2'd0, 2'd0, "R4 hi+1");

    // R5 independent rights
    access(24'h001500, 2'd1, 2'd0, "R5 write denied");
    access(24'h001500, 2'd2, 2'd0, "R5 fetch denied");
    cfg(2'd0, 2'd0, 2'd2, 24'h000006);
    access(24'h001500, 2'd0, 2'd0, "R5 read now denied");
    access(24'h001500, 2'd1, 2'd0, "R5 write");
    access(24'h001500, 2'd2, 2'd0, "R5 fetch");
    cfg(2'd0, 2'd0, 2'd2, 24'h000007);
    access(24'h001500, 2'd3, 2'd0, "R5 reserved");

    // R6 level separation
    access(24'h001500, 2'd0, 2'd1, "R6 other level");
    access(24'h001500, 2'd0, 2'd3, "R6 other level 3");

    // R10 whole space
    win(2'd3, 2'd3, 24'h000000, 24'hFFFFFF, 3'b100);
    access(24'hFFFFFF, 2'd2, 2'd3, "R10 top");
    access(24'h000000, 2'd2, 2'd3, "R10 bottom");

    // R8 same-cycle write uses old value, next cycle new
    @(negedge clk);
    cfg_we = 1; cfg_addr = {2'd1, 2'd2, 2'd2}; cfg_wdata = 24'd1;
    acc_valid = 0; acc_addr = 24'h000000; acc_type = 2'd0; acc_level = 2'd1;
    #1;
    chk(acc_ok == 0, "R8 old", acc_ok, 0);
    @(posedge clk);
    @(negedge clk);
    cfg_we = 0; m_pm[6] = 3'b001;
    #1;
    chk(acc_ok == 1, "R8 new", acc_ok, 1);

    // R7 capture holds after trap pulse ends
    access(24'h00ABCD, 2'd1, 2'd2, "R7 violate");
    @(negedge clk); #1;
    chk(trap == 0 && trap_addr == 24'h00ABCD, "R7 hold", trap_addr, 24'h00ABCD);

    // R3 random regions and accesses
    for (int i = 0; i < 16; i++)
      win(2'(i / 4), 2'(i % 4), 24'($urandom_range(0, 3000)),
          24'($urandom_range(2000, 4095)), 3'($urandom));
    for (int i = 0; i < 300; i++)
      access(24'($urandom_range(0, 4200)), 2'($urandom_range(0, 2)), 2'($urandom), "R3 random");

    // R2 disable again
    cfg(2'd0, 2'd0, 2'd3, 24'd0);
    access(24'h00ABCD, 2'd3, 2'd1, "R2 off again");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule